// File: doc/BRIEF.md
# Four-Channel SAR Converter Serial Port Slave

This block models the digital half of a four-channel, 12-bit successive-approximation converter's serial port. It gives a verification environment a synthesizable converter to talk to. A host frames each transfer with an active-low select and clocks it with a serial clock. The block then returns a conversion result and picks up the channel to use for the following conversion. The analog inputs are replaced by four parallel 12-bit words, concatenated onto one input bus. Channel k occupies bits `[12k+11:12k]` of that bus.

Every frame is divided into 16-clock slots, and each slot performs one conversion. The first three serial clock cycles of a slot are acquisition (track). The remaining thirteen are hold/convert, and the block signals them on `holding`. When hold begins, the word of the currently selected channel is latched. The output line first carries four zero bits and then the twelve latched bits, most significant bit first. While the slot runs, the host supplies a 2-bit address on the data input, and that address takes effect from the next slot onward.

The block runs on a fast system clock `clk`. The select, serial clock and data inputs must already be synchronous to `clk`, and each serial clock level must last at least one `clk` cycle. The serial output has a separate enable, `sdoEn`, and the chip-level pad uses it to tri-state the line.

Top module: `sarSerialSlave`

## Requirements
- R1: `sdoEn` is 1 from the first `clk` cycle after `csN` is sampled low until the first cycle after it is sampled high. While `sdoEn` is 0, `sdo` and `holding` are 0.
- R2: When `sclk` is low as `csN` falls, that select edge counts as the first serial clock falling edge and starts cycle 1 of the first slot.
- R3: When `sclk` is high as `csN` falls, cycle 1 starts at the first real `sclk` falling edge after that.
- R4: `holding` is 0 during cycles 1 to 3 of a slot and 1 during cycles 4 to 16.
- R5: During cycles 1 to 4 of a slot, `sdo` is 0. During cycles 5 to 16 it carries the 12-bit word latched at the start of cycle 4, most significant bit first, one bit per cycle.
- R6: The `din` value on the rising `sclk` edge of cycle 3 is the address MSB and the value on the rising edge of cycle 4 is the LSB. Binary address a selects word a of `chanData`. The `din` value on every other edge has no effect.
- R7: A new address applies from the next slot onward, and this includes the first slot of a later frame. It never applies to the slot that carried it.
- R8: After the 16th rising `sclk` edge of a slot, the next falling edge starts cycle 1 of a new slot in the same frame.
- R9: After reset, channel 0 is selected.
- R10: If a frame ends before the rising edge of cycle 4, the selected channel is unchanged. `sclk` and `din` activity while `csN` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| din | input | 1 | Serial address input |
| chanData | input | 48 | Four 12-bit channel words; channel k at bits 12k+11:12k |
| sdo | output | 1 | Serial result bit |
| sdoEn | output | 1 | Output enable for the serial data pad |
| holding | output | 1 | High during the hold/convert part of a slot |

## Verification
The hardest cases to reach from the ports are the interactions between the select edge and the serial clock level. These include a select edge that itself counts as the first falling edge, a frame cut off between the two address bits, and clock toggling while the frame is closed. Random frames vary the idle clock level, the number of slots per frame and every `din` bit. Directed frames add aborts after cycle 3, partial second slots and gated toggling. A bench model tracks the channel in use and checks every output bit.

// File: rtl/sarSlavePkg.sv
package sarSlavePkg;
  localparam int SLOT_LEN = 16;
  localparam int IDX_W    = $clog2(SLOT_LEN);

  typedef struct packed {
    logic             frameOn;
    logic             slotOn;
    logic [IDX_W-1:0] bitIdx;
    logic             latchSample;
    logic             addrShift;
    logic             addrCommit;
  } slaveStrobe_t;
endpackage

// File: rtl/sarSlaveCtrl.sv
module sarSlaveCtrl
  import sarSlavePkg::*;
#(
  parameter int TRACK_CYC  = 3,
  parameter int ADDR_FIRST = 3,
  parameter int ADDR_W     = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  output slaveStrobe_t strb,
  output logic         holding
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SLOT_LEN - 1);
  localparam logic [IDX_W-1:0] LATCH_IDX = IDX_W'(TRACK_CYC - 1);
  localparam logic [IDX_W-1:0] HOLD_IDX  = IDX_W'(TRACK_CYC);
  localparam logic [IDX_W-1:0] ADDR_LO   = IDX_W'(ADDR_FIRST - 1);
  localparam logic [IDX_W-1:0] ADDR_HI   = IDX_W'(ADDR_FIRST + ADDR_W - 2);

  logic             csNQ;
  logic             sclkQ;
  logic             slotOn;
  logic [IDX_W-1:0] bitIdx;
  logic             fallEv;
  logic             riseEv;

  always_comb begin
    fallEv = !csN && !sclk && (csNQ || sclkQ);
    riseEv = !csN && !csNQ && !sclkQ && sclk && slotOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csNQ   <= 1'b1;
      sclkQ  <= 1'b0;
      slotOn <= 1'b0;
      bitIdx <= '0;
    end else begin
      csNQ  <= csN;
      sclkQ <= sclk;
      if (csN) begin
        slotOn <= 1'b0;
        bitIdx <= '0;
      end else if (fallEv) begin
        slotOn <= 1'b1;
        if (!slotOn || bitIdx == LAST_IDX) bitIdx <= '0;
        else                               bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.frameOn     = !csNQ;
    strb.slotOn      = slotOn;
    strb.bitIdx      = bitIdx;
    strb.latchSample = fallEv && slotOn && (bitIdx == LATCH_IDX);
    strb.addrShift   = riseEv && (bitIdx >= ADDR_LO) && (bitIdx <= ADDR_HI);
    strb.addrCommit  = riseEv && (bitIdx == ADDR_HI);
    holding          = slotOn && (bitIdx >= HOLD_IDX);
  end

  // R1
  slot_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !slotOn);

  // R2
  slot_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotOn) |-> bitIdx == '0);

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotOn && $past(slotOn) && bitIdx != $past(bitIdx)) |->
      (bitIdx == $past(bitIdx) + 1'b1) || (bitIdx == '0 && $past(bitIdx) == LAST_IDX));
endmodule

// File: rtl/sarSlaveData.sv
module sarSlaveData
  import sarSlavePkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     din,
  input  logic [NUM_CH*DATA_W-1:0] chanData,
  input  slaveStrobe_t             strb,
  output logic                     sdo
);
  localparam int LEAD = SLOT_LEN - DATA_W;
  localparam logic [IDX_W-1:0] LEAD_IDX = IDX_W'(LEAD);

  logic [DATA_W-1:0] chanWord [NUM_CH];
  logic [ADDR_W-1:0] chanSel;
  logic [ADDR_W-1:0] addrAcc;
  logic [ADDR_W:0]   addrWide;
  logic [DATA_W-1:0] sampleReg;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_word
    assign chanWord[c] = chanData[c*DATA_W +: DATA_W];
  end

  assign addrWide = {addrAcc, din};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel   <= '0;
      addrAcc   <= '0;
      sampleReg <= '0;
    end else begin
      if (strb.addrShift)   addrAcc   <= addrWide[ADDR_W-1:0];
      if (strb.addrCommit)  chanSel   <= addrWide[ADDR_W-1:0];
      if (strb.latchSample) sampleReg <= chanWord[chanSel];
    end
  end

  always_comb begin
    sdo = 1'b0;
    if (strb.slotOn && strb.bitIdx >= LEAD_IDX)
      sdo = sampleReg[SLOT_LEN - 1 - int'(strb.bitIdx)];
  end

  // R7
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.addrCommit |=> $stable(chanSel));

  // R5
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitIdx < LEAD_IDX) |-> !sdo);

  // R5
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchSample |=> $stable(sampleReg));
endmodule

// File: rtl/sarSerialSlave.sv
module sarSerialSlave
  import sarSlavePkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 12,
  parameter int TRACK_CYC  = 3,
  parameter int ADDR_FIRST = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     din,
  input  logic [NUM_CH*DATA_W-1:0] chanData,
  output logic                     sdo,
  output logic                     sdoEn,
  output logic                     holding
);
  localparam int ADDR_W = $clog2(NUM_CH);

  slaveStrobe_t strb;
  logic         sdoRaw;

  sarSlaveCtrl #(
    .TRACK_CYC (TRACK_CYC),
    .ADDR_FIRST(ADDR_FIRST),
    .ADDR_W    (ADDR_W)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .strb   (strb),
    .holding(holding)
  );

  sarSlaveData #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .din     (din),
    .chanData(chanData),
    .strb    (strb),
    .sdo     (sdoRaw)
  );

  assign sdo   = sdoRaw && strb.frameOn;
  assign sdoEn = strb.frameOn;

  // R1
  en_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> (!sdo && !holding));
endmodule

// File: tb/sarSerialSlave_tb_top.sv
module sarSerialSlave_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [47:0] chanData = '0;
  logic        sdo, sdoEn, holding;

  int nChecks = 0;
  int nFails  = 0;
  int expChan = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sarSerialSlave dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .chanData(chanData), .sdo(sdo), .sdoEn(sdoEn), .holding(holding)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expBit(input logic [11:0] w, input int idx);
    return (idx < 4) ? 1'b0 : w[15 - idx];
  endfunction

  // one serial clock period: fall, sample, rise with din
  task automatic sclkBit(input logic dinV, output logic sdoV, output logic holdV, output logic enV);
    sclk = 1'b0;
    @(negedge clk);
    sdoV = sdo; holdV = holding; enV = sdoEn;
    din = dinV; sclk = 1'b1;
    @(negedge clk);
  endtask

  // addr < 0: random address bits
  task automatic runFrame(input int nBits, input bit idleHigh, input int addr);
    logic [11:0] word;
    logic [1:0]  pend;
    logic        s, h, e, dv;
    word = '0; pend = '0;
    sclk = idleHigh;
    @(negedge clk); @(negedge clk);
    csN = 1'b0;
    if (idleHigh) begin
      @(negedge clk);
      check(sdo == 1'b0 && holding == 1'b0, "R3 pre-fall idle", {sdo, holding}, 0);
    end
    for (int b = 0; b < nBits; b++) begin
      int idx = b % 16;
      if (idx == 0) word = chanData[expChan*12 +: 12];
      dv = $urandom_range(0, 1);
      if (addr >= 0 && idx == 2) dv = addr[1];
      if (addr >= 0 && idx == 3) dv = addr[0];
      if (idx == 2) pend[1] = dv;
      if (idx == 3) pend[0] = dv;
      sclkBit(dv, s, h, e);
      check(e == 1'b1, "R1 enable in frame", e, 1);
      check(s == expBit(word, idx), idleHigh ? "R3/R5/R8 sdo bit" : "R2/R5/R8 sdo bit", s, expBit(word, idx));
      check(h == (idx >= 3), "R4 holding", h, idx >= 3);
      if (idx == 3) expChan = pend;  // R6 R7: takes effect after the cycle-4 rise
    end
    csN = 1'b1;
    @(negedge clk);
    check(sdoEn == 1'b0 && sdo == 1'b0 && holding == 1'b0, "R1 frame end",
          {sdoEn, sdo, holding}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (test completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    chanData = {12'hA5C, 12'h3F1, 12'h96E, 12'h7B2};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sdoEn == 1'b0 && sdo == 1'b0 && holding == 1'b0, "R1 reset state",
          {sdoEn, sdo, holding}, 0);

    // R9: first slot after reset returns channel 0 word
    runFrame(16, 1'b0, 2);
    check(expChan == 2, "R6 model address", expChan, 2);
    // R7: next frame uses channel 2, sets 1
    runFrame(16, 1'b1, 1);
    // R10: abort after cycle 3 rise, MSB set but channel stays 1
    runFrame(3, 1'b0, 3);
    check(expChan == 1, "R10 abort model", expChan, 1);
    runFrame(16, 1'b1, 3);
    // R10: gated toggling while csN high
    for (int k = 0; k < 40; k++) begin
      sclk = ~sclk; din = $urandom_range(0, 1);
      @(negedge clk);
      check(sdoEn == 1'b0 && sdo == 1'b0, "R10 gated idle", {sdoEn, sdo}, 0);
    end
    runFrame(16, 1'b0, 0);
    // R8: multi-slot frame with partial third slot
    runFrame(40, 1'b1, -1);

    for (int f = 0; f < 60; f++) begin
      chanData = {$urandom_range(0, 4095), $urandom_range(0, 4095)};
      chanData[47:24] = {12'($urandom_range(0, 4095)), 12'($urandom_range(0, 4095))};
      runFrame(16 * $urandom_range(1, 3) + (($urandom_range(0, 3) == 0) ? $urandom_range(1, 15) : 0),
               1'($urandom_range(0, 1)), -1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule